// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit side of a 10 Mb/s twisted-pair port against a stuck transmitter. It times each continuous stretch of transmit activity against a millisecond tick. When one stretch runs past a configured limit, the block enters a jabber mode. In that mode it withdraws both the transmit enable and the loopback enable.

Once in jabber mode, the block returns to normal operation only after the transmit input has been idle for an unbroken stretch of a second configured length. Any activity during that idle wait restarts the wait from zero. On entry to jabber mode a sticky status bit is set. That bit, gated by an enable input, forms an interrupt request. The bit stays set until a clear strobe arrives.

Top module: `jabber_guard`

## Requirements
- R1: Jabber mode is entered on the ms_tick that makes the count of ticks seen during one unbroken stretch of tx_active high exceed TX_LIMIT_MS. A stretch that sees exactly TX_LIMIT_MS ticks does not enter jabber mode.
- R2: In normal mode tx_en and lpbk_en are both 1. In jabber mode both are 0.
- R3: jab_stat becomes 1 in the same clock cycle in which tx_en and lpbk_en drop on entry to jabber mode.
- R4: irq equals jab_stat AND irq_en at all times.
- R5: Jabber mode is left on the ms_tick that completes UNJAB_MS consecutive ticks with tx_active low. Any cycle with tx_active high during jabber mode restarts this count from zero.
- R6: jab_stat stays 1 until a cycle with stat_clr high. A set and a clear in the same cycle leave it at 1. Clearing it does not end jabber mode.
- R7: In normal mode, a single cycle with tx_active low resets the transmit duration count to zero.
- R8: Time advances only on ms_tick, so tx_active held high without ticks never causes jabber. After reset the block is in normal mode with jab_stat at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tx_active | input | 1 | Transmit data present |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Clear strobe for the jabber status bit |
| tx_en | output | 1 | Transmit path enable |
| lpbk_en | output | 1 | Loopback path enable |
| jab_stat | output | 1 | Sticky jabber status bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives exactly TX_LIMIT_MS ticks of activity and checks that the enables stay up. It then applies one more tick and checks that they drop. A design off by one in either direction fails one of those two checks. A one-cycle gap in activity, and separately a one-cycle burst during the idle wait, show whether each counter really restarts. A design that only pauses its count would jab early or release early. The bench also sets and clears the status bit in the same cycle, clears it in the middle of jabber mode, and holds activity without ticks. These catch a wrong priority between set and clear, a clear that wrongly releases the port, and a design that counts clocks instead of ticks.

// File: rtl/jg_pkg.sv
package jg_pkg;
  typedef enum logic {
    MODE_RUN = 1'b0,
    MODE_JAB = 1'b1
  } jg_mode_e;
endpackage

// File: rtl/jg_tick_timer.sv
// Counts ms ticks while run is high; any cycle with run low clears it.
// fire pulses on the tick that completes TARGET ticks.
module jg_tick_timer #(
  parameter int TARGET = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic fire
);
  localparam int CW = (TARGET > 1) ? $clog2(TARGET) : 1;
  localparam logic [CW-1:0] LAST = CW'(TARGET - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign fire = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run || fire) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7 / R5: a cycle without run leaves the count at zero
  a_r7_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R1: count never passes the terminal value
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/jg_mode_fsm.sv
module jg_mode_fsm
  import jg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_fire,
  input  logic     idle_fire,
  output jg_mode_e mode
);
  jg_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_RUN: if (tx_fire)   mode_d = MODE_JAB;
      MODE_JAB: if (idle_fire) mode_d = MODE_RUN;
      default:                 mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R5: jabber mode is held until the idle wait completes
  a_r5_hold_jab: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_JAB && !idle_fire) |=> (mode_q == MODE_JAB));
endmodule

// File: rtl/jg_status.sv
module jg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic stat,
  output logic irq
);
  logic stat_q, stat_d, stat_en;

  always_comb begin
    stat_en = set || clr;
    stat_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = stat_q && irq_en;

  // R6: status is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr) |=> stat_q);
  // R6: set wins over a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> stat_q);
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jg_pkg::*;
#(
  parameter int TX_LIMIT_MS = 100,
  parameter int UNJAB_MS    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_active,
  input  logic irq_en,
  input  logic stat_clr,
  output logic tx_en,
  output logic lpbk_en,
  output logic jab_stat,
  output logic irq
);
  localparam int TX_TARGET = TX_LIMIT_MS + 1;

  jg_mode_e mode;
  logic     tx_run, idle_run, tx_fire, idle_fire;

  assign tx_run   = tx_active  && (mode == MODE_RUN);
  assign idle_run = !tx_active && (mode == MODE_JAB);

  jg_tick_timer #(.TARGET(TX_TARGET)) u_tx_timer (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .run(tx_run), .fire(tx_fire)
  );

  jg_tick_timer #(.TARGET(UNJAB_MS)) u_idle_timer (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .run(idle_run), .fire(idle_fire)
  );

  jg_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_fire(tx_fire), .idle_fire(idle_fire), .mode(mode)
  );

  jg_status u_status (
    .clk(clk), .rst_n(rst_n), .set(tx_fire), .clr(stat_clr),
    .irq_en(irq_en), .stat(jab_stat), .irq(irq)
  );

  assign tx_en   = (mode == MODE_RUN);
  assign lpbk_en = (mode == MODE_RUN);

  // R3: enables drop together with the status rising
  a_r3_set_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> jab_stat);
  // R1: entry only on a tick during activity
  a_r1_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> ($past(tx_active) && $past(ms_tick)));
  // R5: release only after an idle cycle
  a_r5_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !$past(tx_active));
  // R4: request implies enabled status
  a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (jab_stat && irq_en));
endmodule

// File: tb/jabber_guard_bench.sv
module jabber_guard_bench;
  localparam int TXL = 6;
  localparam int UNJ = 5;

  logic clk, rst_n, ms_tick, tx_active, irq_en, stat_clr;
  logic tx_en, lpbk_en, jab_stat, irq;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  jabber_guard #(.TX_LIMIT_MS(TXL), .UNJAB_MS(UNJ)) u_jabber_guard (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tx_active(tx_active),
    .irq_en(irq_en), .stat_clr(stat_clr), .tx_en(tx_en), .lpbk_en(lpbk_en),
    .jab_stat(jab_stat), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic en_exp, input logic st_exp);
    chk({req, " tx_en"}, tx_en, en_exp);
    chk({req, " lpbk_en"}, lpbk_en, en_exp);
    chk({req, " jab_stat"}, jab_stat, st_exp);
    chk({req, " irq"}, irq, st_exp & irq_en);
  endtask

  // one tick cycle followed by one quiet cycle; inputs change at negedge
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk_mode("R8 reset", 1'b1, 1'b0);
  endtask

  task automatic t_no_tick;
    tx_active = 1'b1;
    repeat (60) @(negedge clk);
    chk_mode("R8 no ticks", 1'b1, 1'b0);
    tx_active = 1'b0;
    ticks(20);
    chk_mode("R8 idle ticks", 1'b1, 1'b0);
  endtask

  task automatic t_enter;
    irq_en = 1'b1;
    tx_active = 1'b1;
    ticks(TXL);
    chk_mode("R1 at limit", 1'b1, 1'b0);
    tx_active = 1'b0;
    @(negedge clk);
    tx_active = 1'b1;
    ticks(TXL);
    chk_mode("R7 restart after gap", 1'b1, 1'b0);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    chk_mode("R1 R2 R3 jabber entry", 1'b0, 1'b1);
    irq_en = 1'b0;
    #1;
    chk("R4 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    #1;
    chk("R4 irq enabled", irq, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_exit;
    tx_active = 1'b0;
    ticks(UNJ - 1);
    chk_mode("R5 idle short", 1'b0, 1'b1);
    tx_active = 1'b1;
    @(negedge clk);
    tx_active = 1'b0;
    ticks(UNJ - 1);
    chk_mode("R5 restart after burst", 1'b0, 1'b1);
    ticks(1);
    chk_mode("R5 release", 1'b1, 1'b1);
    irq_en = 1'b0;
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk_mode("R6 cleared", 1'b1, 1'b0);
  endtask

  task automatic t_priority;
    tx_active = 1'b1;
    ticks(TXL);
    stat_clr = 1'b1;
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    stat_clr = 1'b0;
    chk_mode("R6 set wins", 1'b0, 1'b1);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    tx_active = 1'b0;
    ticks(UNJ - 1);
    chk_mode("R6 clear keeps jabber", 1'b0, 1'b0);
    ticks(1);
    chk_mode("R5 second release", 1'b1, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; tx_active = 1'b0;
    irq_en = 1'b0; stat_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_tick();
    t_enter();
    t_exit();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule